// File: doc/BRIEF.md
# ECC Error Status Logger

This block records DRAM ECC error events from up to two memory channels so that software can inspect them later. Each channel presents a correctable-error pulse and an uncorrectable-error pulse. Each pulse carries the failing column, row, bank, rank and syndrome. The block keeps one 64-bit log word per channel and one shared 16-bit status word. Software reads and writes these through a small combinational register port.

A log holds the first error it sees. Only a more severe error can replace it: an uncorrectable error overwrites a correctable entry, and nothing overwrites an uncorrectable entry.

Software acknowledges errors by writing ones to the status bits. Writing both status bits at once also empties the flags of every log, which re-arms capture. A configuration input restricts the block to channel 0 only. Every error event beats a clearing write that lands in the same cycle.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset the status word (address 0x040) and both log words (addresses 0x280 and 0x680) read as zero.
- R2: A correctable pulse on an active channel sets status bit 0 on the next clock. An uncorrectable pulse sets status bit 1 on the next clock.
- R3: A write to the status address clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R4: When an error pulse and a clearing write to the same status bit fall in the same cycle, the bit is set after that cycle.
- R5: A correctable error on a log with both flags clear is stored with these fields:
  - column in bits 63:48
  - row in bits 47:32
  - bank in bits 31:29
  - rank in bits 28:27
  - syndrome in bits 23:16
  - bit 0 = 1 and bit 1 = 0
- R6: An uncorrectable error on a log whose bit 1 is clear replaces the whole entry with its own fields, with bit 1 = 1 and bit 0 = 0. This includes replacing a held correctable entry.
- R7: The log does not change in two cases:
  - a correctable error arrives while either flag of that log is set;
  - an uncorrectable error arrives while bit 1 is set.
- R8: Simultaneous correctable and uncorrectable pulses on one channel store the uncorrectable entry and set both status bits.
- R9: The two channel logs are independent. Channel 0 is read at 0x280 and channel 1 at 0x680.
- R10: While singleChan is 1, channel 1 pulses change neither the log at 0x680 nor the status word. Channel 0 still captures errors.
- R11: A status write with data 2'b11 also clears bits 1:0 of every log and keeps the other log fields. Any other write value leaves the log flags alone.
- R12: Reserved bits read as zero: log bits 26:24 and 15:2, and status bits 15:2. Writes to log addresses are ignored. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| singleChan | input | 1 | 1 = only channel 0 is active |
| ceIn | input | NCH | Correctable-error pulse per channel |
| ueIn | input | NCH | Uncorrectable-error pulse per channel |
| errCol | input | NCH x 16 | Failing column per channel |
| errRow | input | NCH x 16 | Failing row per channel |
| errBank | input | NCH x 3 | Failing bank per channel |
| errRank | input | NCH x 2 | Failing rank per channel |
| errSynd | input | NCH x 8 | ECC syndrome per channel |
| regAddr | input | 12 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 2 | Write-one-to-clear mask for status bits 1:0 |
| regRdData | output | 64 | Combinational read data for regAddr |

## Verification
The bench builds the block with the default two channels. Both log offsets, the cross-channel independence and the single-channel restriction of channel 1 are therefore all exercised. Because two channels exist, a clearing write can collide with a capture on one channel while it wipes the flags of the other. A single-channel build would never reach that collision.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
  localparam int COL_W  = 16;
  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;
  localparam int RANK_W = 2;
  localparam int SYND_W = 8;
  localparam int LOG_W  = 64;
  localparam int STAT_W = 16;
  localparam int FLAG_W = 2;

  typedef struct packed {
    logic capUe;
    logic capCe;
    logic clrFlags;
  } chStrobe_t;

  function automatic logic [LOG_W-1:0] packLog(
    input logic [COL_W-1:0]  col,
    input logic [ROW_W-1:0]  row,
    input logic [BANK_W-1:0] bank,
    input logic [RANK_W-1:0] rank,
    input logic [SYND_W-1:0] synd,
    input logic              isUe
  );
    return {col, row, bank, rank, 3'b000, synd, 14'b0, isUe, ~isUe};
  endfunction
endpackage

// File: rtl/ecclog_ctrl.sv
module ecclog_ctrl
  import ecclog_pkg::*;
#(
  parameter int NCH = 2,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h040
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        singleChan,
  input  logic [NCH-1:0]              ceIn,
  input  logic [NCH-1:0]              ueIn,
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [FLAG_W-1:0]           regWrData,
  input  logic [NCH-1:0][FLAG_W-1:0]  flagsQ,
  output chStrobe_t [NCH-1:0]         strobe,
  output logic [STAT_W-1:0]           statusQ
);
  logic [NCH-1:0] actMask;
  logic [NCH-1:0] ceAct, ueAct;
  logic           wrStat, clrAll;
  logic [FLAG_W-1:0] statFlags;

  assign wrStat = regWrEn && (regAddr == STAT_ADDR);
  assign clrAll = wrStat && (regWrData == 2'b11);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [FLAG_W-1:0] effFlags;
    assign actMask[c] = (c == 0) || !singleChan;
    assign ceAct[c]   = ceIn[c] && actMask[c];
    assign ueAct[c]   = ueIn[c] && actMask[c];
    assign effFlags   = clrAll ? '0 : flagsQ[c];
    assign strobe[c].capUe    = ueAct[c] && !effFlags[1];
    assign strobe[c].capCe    = ceAct[c] && !ueAct[c] && (effFlags == '0);
    assign strobe[c].clrFlags = clrAll;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statFlags <= '0;
    end else begin
      statFlags[0] <= (|ceAct) | (statFlags[0] & ~(wrStat & regWrData[0]));
      statFlags[1] <= (|ueAct) | (statFlags[1] & ~(wrStat & regWrData[1]));
    end
  end

  assign statusQ = {{(STAT_W-FLAG_W){1'b0}}, statFlags};
endmodule

// File: rtl/ecclog_datapath.sv
module ecclog_datapath
  import ecclog_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  chStrobe_t [NCH-1:0]         strobe,
  input  logic [NCH-1:0][COL_W-1:0]   errCol,
  input  logic [NCH-1:0][ROW_W-1:0]   errRow,
  input  logic [NCH-1:0][BANK_W-1:0]  errBank,
  input  logic [NCH-1:0][RANK_W-1:0]  errRank,
  input  logic [NCH-1:0][SYND_W-1:0]  errSynd,
  output logic [NCH-1:0][LOG_W-1:0]   logQ,
  output logic [NCH-1:0][FLAG_W-1:0]  flagsQ
);
  for (genvar c = 0; c < NCH; c++) begin : g_log
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        logQ[c] <= '0;
      end else if (strobe[c].capUe) begin
        logQ[c] <= packLog(errCol[c], errRow[c], errBank[c], errRank[c], errSynd[c], 1'b1);
      end else if (strobe[c].capCe) begin
        logQ[c] <= packLog(errCol[c], errRow[c], errBank[c], errRank[c], errSynd[c], 1'b0);
      end else if (strobe[c].clrFlags) begin
        logQ[c][FLAG_W-1:0] <= '0;
      end
    end
    assign flagsQ[c] = logQ[c][FLAG_W-1:0];
  end
endmodule

// File: rtl/ecclog_regread.sv
module ecclog_regread
  import ecclog_pkg::*;
#(
  parameter int NCH = 2,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 12'h040,
  parameter logic [ADDR_W-1:0] LOG_BASE   = 12'h280,
  parameter logic [ADDR_W-1:0] LOG_STRIDE = 12'h400
) (
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [STAT_W-1:0]          statusQ,
  input  logic [NCH-1:0][LOG_W-1:0]  logQ,
  output logic [LOG_W-1:0]           regRdData
);
  logic [NCH-1:0] logHit;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(LOG_BASE + LOG_STRIDE * c);
    assign logHit[c] = (regAddr == CH_ADDR);
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == STAT_ADDR) regRdData = {{(LOG_W-STAT_W){1'b0}}, statusQ};
    for (int c = 0; c < NCH; c++) begin
      if (logHit[c]) regRdData = logQ[c];
    end
  end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecclog_pkg::*;
#(
  parameter int NCH = 2,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 12'h040,
  parameter logic [ADDR_W-1:0] LOG_BASE   = 12'h280,
  parameter logic [ADDR_W-1:0] LOG_STRIDE = 12'h400
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        singleChan,
  input  logic [NCH-1:0]              ceIn,
  input  logic [NCH-1:0]              ueIn,
  input  logic [NCH-1:0][COL_W-1:0]   errCol,
  input  logic [NCH-1:0][ROW_W-1:0]   errRow,
  input  logic [NCH-1:0][BANK_W-1:0]  errBank,
  input  logic [NCH-1:0][RANK_W-1:0]  errRank,
  input  logic [NCH-1:0][SYND_W-1:0]  errSynd,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [FLAG_W-1:0]           regWrData,
  output logic [LOG_W-1:0]            regRdData
);
  chStrobe_t [NCH-1:0]        strobe;
  logic [NCH-1:0][FLAG_W-1:0] flagsQ;
  logic [NCH-1:0][LOG_W-1:0]  logQ;
  logic [STAT_W-1:0]          statusQ;

  ecclog_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .singleChan(singleChan),
    .ceIn(ceIn), .ueIn(ueIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .flagsQ(flagsQ), .strobe(strobe), .statusQ(statusQ)
  );

  ecclog_datapath #(.NCH(NCH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .errCol(errCol), .errRow(errRow), .errBank(errBank),
    .errRank(errRank), .errSynd(errSynd),
    .logQ(logQ), .flagsQ(flagsQ)
  );

  ecclog_regread #(.NCH(NCH), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
                   .LOG_BASE(LOG_BASE), .LOG_STRIDE(LOG_STRIDE)) u_rd (
    .regAddr(regAddr), .statusQ(statusQ), .logQ(logQ), .regRdData(regRdData)
  );
endmodule

// File: rtl/ecclog_checker.sv
module ecclog_checker
  import ecclog_pkg::*;
#(
  parameter int NCH = 2,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h040
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        singleChan,
  input logic [NCH-1:0]              ceIn,
  input logic [NCH-1:0]              ueIn,
  input logic [NCH-1:0][ROW_W-1:0]   errRow,
  input logic [ADDR_W-1:0]           regAddr,
  input logic                        regWrEn,
  input logic [FLAG_W-1:0]           regWrData,
  input logic [STAT_W-1:0]           statusQ,
  input logic [NCH-1:0][LOG_W-1:0]   logQ
);
  logic clrAll, quiet;
  assign clrAll = regWrEn && regAddr == STAT_ADDR && regWrData == 2'b11;
  assign quiet  = (ceIn == '0) && (ueIn == '0);

  // R2 and R4: an event sets its bit even under a clearing write
  p_ce_sets_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ceIn[0] |=> statusQ[0]);
  p_ue_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ueIn[0] |=> statusQ[1]);
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clrAll && quiet) |=> statusQ[FLAG_W-1:0] == 2'b00);
  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clrAll && quiet) |=> logQ[0][FLAG_W-1:0] == 2'b00);
  p_ue_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ueIn[0] && !logQ[0][1]) |=> (logQ[0][1:0] == 2'b10 && logQ[0][47:32] == $past(errRow[0])));
  p_ce_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ceIn[0] && !ueIn[0] && logQ[0][1:0] != 2'b00 && !clrAll) |=> $stable(logQ[0]));
  p_status_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    statusQ[STAT_W-1:FLAG_W] == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      logQ[c][1:0] != 2'b11);
    p_log_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (logQ[c][26:24] == 3'b000 && logQ[c][15:2] == 14'b0));
  end

  if (NCH > 1) begin : g_single
    p_single_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (singleChan && !clrAll) |=> $stable(logQ[NCH-1]));
  end
endmodule

bind ecc_err_logger ecclog_checker #(.NCH(NCH), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .singleChan(singleChan), .ceIn(ceIn), .ueIn(ueIn),
  .errRow(errRow), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
  .statusQ(statusQ), .logQ(logQ)
);

// File: tb/tb_ecc_err_logger.sv
`timescale 1ns/1ps
module tb_ecc_err_logger;
  localparam int NCH = 2;
  localparam logic [11:0] A_STAT = 12'h040;
  localparam logic [11:0] A_LOG0 = 12'h280;
  localparam logic [11:0] A_LOG1 = 12'h680;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic singleChan = 1'b0;
  logic [NCH-1:0] ceIn = '0, ueIn = '0;
  logic [NCH-1:0][15:0] errCol = '0, errRow = '0;
  logic [NCH-1:0][2:0]  errBank = '0;
  logic [NCH-1:0][1:0]  errRank = '0;
  logic [NCH-1:0][7:0]  errSynd = '0;
  logic [11:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regWrData = '0;
  logic [63:0] regRdData;

  int nRun = 0, nFail = 0;

  always #10 clk = ~clk;

  ecc_err_logger dut (
    .clk(clk), .rst_n(rst_n), .singleChan(singleChan), .ceIn(ceIn), .ueIn(ueIn),
    .errCol(errCol), .errRow(errRow), .errBank(errBank), .errRank(errRank),
    .errSynd(errSynd), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] wd;
    logic [1:0] ce;
    logic [1:0] ue;
    logic [1:0] st;
    logic [1:0] f0;
    logic [1:0] f1;
  } vec_t;

  // wr, wdata, ce[1:0], ue[1:0], expected status, ch0 flags, ch1 flags
  localparam vec_t TBL [10] = '{
    '{1'b0, 2'b00, 2'b01, 2'b00, 2'b01, 2'b01, 2'b00},  // R2 R5 ce ch0
    '{1'b0, 2'b00, 2'b00, 2'b10, 2'b11, 2'b01, 2'b10},  // R9 ue ch1 only
    '{1'b0, 2'b00, 2'b10, 2'b00, 2'b11, 2'b01, 2'b10},  // R7 ce on full log
    '{1'b1, 2'b01, 2'b00, 2'b00, 2'b10, 2'b01, 2'b10},  // R3 clear bit0
    '{1'b0, 2'b00, 2'b00, 2'b01, 2'b10, 2'b10, 2'b10},  // R6 ue over ce
    '{1'b1, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00},  // R11 clear all
    '{1'b0, 2'b00, 2'b01, 2'b01, 2'b11, 2'b10, 2'b00},  // R8 both same cycle
    '{1'b1, 2'b00, 2'b00, 2'b00, 2'b11, 2'b10, 2'b00},  // R3 zero write
    '{1'b1, 2'b11, 2'b10, 2'b00, 2'b01, 2'b00, 2'b01},  // R4 event beats clear
    '{1'b1, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01}   // R11 partial write
  };

  function automatic logic [63:0] mkLog(input logic [15:0] col, row, input logic [2:0] bank,
                                        input logic [1:0] rank, input logic [7:0] synd,
                                        input logic ue);
    logic [63:0] w;
    w = '0;
    w[63:48] = col; w[47:32] = row; w[31:29] = bank; w[28:27] = rank;
    w[23:16] = synd; w[1] = ue; w[0] = !ue;
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic setFields(input int ch, input logic [15:0] col, row, input logic [2:0] bank,
                           input logic [1:0] rank, input logic [7:0] synd);
    errCol[ch] = col; errRow[ch] = row; errBank[ch] = bank;
    errRank[ch] = rank; errSynd[ch] = synd;
  endtask

  task automatic step(input logic [1:0] ce, ue, input logic wr, input logic [1:0] wd);
    @(negedge clk);
    ceIn = ce; ueIn = ue; regWrEn = wr; regWrData = wd; regAddr = A_STAT;
    @(negedge clk);
    ceIn = '0; ueIn = '0; regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #3_000_000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [63:0] d, expLog;
    doReset();
    // R1 reset state
    rd(A_STAT, d); check("R1 status", d, '0);
    rd(A_LOG0, d); check("R1 log0", d, '0);
    rd(A_LOG1, d); check("R1 log1", d, '0);

    foreach (TBL[i]) begin
      setFields(0, 16'hA000 + 16'(i), 16'h0100 + 16'(i), 3'(i), 2'(i), 8'(i));
      setFields(1, 16'hB000 + 16'(i), 16'h0200 + 16'(i), 3'(i), 2'(i), 8'(i));
      step(TBL[i].ce, TBL[i].ue, TBL[i].wr, TBL[i].wd);
      rd(A_STAT, d); check($sformatf("R2 R3 R4 status step %0d", i), d, {62'b0, TBL[i].st});
      rd(A_LOG0, d); check($sformatf("R9 log0 flags step %0d", i), {62'b0, d[1:0]}, {62'b0, TBL[i].f0});
      rd(A_LOG1, d); check($sformatf("R9 log1 flags step %0d", i), {62'b0, d[1:0]}, {62'b0, TBL[i].f1});
    end

    // directed: field layout and replacement rules
    doReset();
    setFields(0, 16'h1234, 16'h5678, 3'd5, 2'd2, 8'hA5);
    step(2'b01, 2'b00, 1'b0, 2'b00);
    expLog = mkLog(16'h1234, 16'h5678, 3'd5, 2'd2, 8'hA5, 1'b0);
    rd(A_LOG0, d); check("R5 ce layout", d, expLog);
    check("R12 rsvd bits", {50'b0, d[26:24], d[15:2]}, '0);

    setFields(0, 16'h1111, 16'h2222, 3'd1, 2'd1, 8'h11);
    step(2'b01, 2'b00, 1'b0, 2'b00);
    rd(A_LOG0, d); check("R7 ce held", d, expLog);

    setFields(0, 16'hBEEF, 16'hCAFE, 3'd7, 2'd3, 8'h3C);
    step(2'b00, 2'b01, 1'b0, 2'b00);
    expLog = mkLog(16'hBEEF, 16'hCAFE, 3'd7, 2'd3, 8'h3C, 1'b1);
    rd(A_LOG0, d); check("R6 ue replaces ce", d, expLog);

    setFields(0, 16'h0F0F, 16'hF0F0, 3'd2, 2'd0, 8'h77);
    step(2'b00, 2'b01, 1'b0, 2'b00);
    rd(A_LOG0, d); check("R7 ue held", d, expLog);

    // R12 write to log address is ignored
    @(negedge clk); regAddr = A_LOG0; regWrEn = 1'b1; regWrData = 2'b11;
    @(negedge clk); regWrEn = 1'b0; regWrData = '0;
    rd(A_LOG0, d); check("R12 log write ignored", d, expLog);
    rd(12'h100, d); check("R12 unmapped reads zero", d, '0);

    // R11 clear-all keeps fields
    step(2'b00, 2'b00, 1'b1, 2'b11);
    expLog[1:0] = 2'b00;
    rd(A_LOG0, d); check("R11 flags cleared fields kept", d, expLog);
    rd(A_STAT, d); check("R3 status cleared", d, '0);

    // R10 single channel
    singleChan = 1'b1;
    setFields(1, 16'h9999, 16'h8888, 3'd3, 2'd1, 8'h42);
    step(2'b10, 2'b10, 1'b0, 2'b00);
    rd(A_LOG1, d); check("R10 ch1 log ignored", d, '0);
    rd(A_STAT, d); check("R10 ch1 status ignored", d, '0);
    setFields(0, 16'h0042, 16'h0043, 3'd4, 2'd3, 8'h5A);
    step(2'b01, 2'b00, 1'b0, 2'b00);
    rd(A_LOG0, d); check("R10 ch0 active", d, mkLog(16'h0042, 16'h0043, 3'd4, 2'd3, 8'h5A, 1'b0));
    rd(A_STAT, d); check("R10 ch0 status", d, 64'h1);
    singleChan = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule